// File: doc/BRIEF.md
# Framing Event Status Register

This block sits beside a T1/E1 framer and turns its frame-boundary strobes into sticky, host-visible event flags. It follows the receive and transmit frame pulses with its own frame counters, so it knows where each side is inside a multiframe. From those positions it raises events at align frames, at multiframe boundaries and at CRC-4 multiframe boundaries. It also watches the receive time slot 16 byte for the two signaling alarm conditions. The multiframe length depends on the line mode: 16 frames in E1, 12 frames with T1 D4 superframing, 24 frames with T1 extended superframing. At 125 µs per frame, this gives the 2 ms, 1.5 ms and 3 ms event periods.

Each event sets one bit of an 8-bit status word. The bit stays set until the host writes a one to it. A second 8-bit word masks the status bits, and the interrupt output is high while any unmasked bit is set. When CRC-4 is enabled, the receive CRC-4 multiframe event follows the framer's CRC-4 alignment strobe. When CRC-4 is disabled, the event still fires every 16 receive frames from a free-running counter that no alignment strobe can move.

Top module: `fes_event_status`

## Requirements
- R1: After reset, both host words read 0 and `irq` is 0. Bit 7 of each word always reads 0. `host_addr` 0 selects the status word (bit 0 receive align, 1 receive CRC-4 multiframe, 2 receive multiframe, 3 transmit align, 4 transmit multiframe, 5 receive slot-16 all zeros, 6 receive slot-16 all ones). `host_addr` 1 selects the mask word, whose bits line up with the status bits.
- R2: In E1 mode, a receive (transmit) frame pulse whose frame index is even sets bit 0 (bit 3). A frame index is the frame's position in the multiframe, counted from 0.
- R3: A receive (transmit) frame pulse at frame index 0 sets bit 2 (bit 4). The index wraps after 16 frames in E1, 12 frames in T1 D4 (`t1_esf`=0) and 24 frames in T1 ESF (`t1_esf`=1). A frame pulse that comes with its side's multiframe sync input is taken as frame index 0.
- R4: In E1 mode with `crc4_en`=1, a receive frame pulse that comes with `rx_crc4_sync` sets bit 1.
- R5: In E1 mode with `crc4_en`=0, bit 1 sets on the first receive frame after reset and on every 16th receive frame after that. The sync inputs have no effect on this.
- R6: In E1 mode, bit 5 sets at receive frame index 15 when all 16 slot-16 bytes of frames 0 to 15 were 0x00.
- R7: In E1 mode, bit 6 sets at receive frame index 15 when the 16 slot-16 bytes of frames 0 to 15 held fewer than three zero bits in total.
- R8: In T1 mode, bits 0, 1, 3, 5 and 6 never set.
- R9: Status bits are sticky. A write to address 0 clears exactly the bits written as 1. No status bit changes without a frame pulse or such a write.
- R10: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: `irq` is 1 exactly while some status bit and its mask bit are both 1. Writing the mask does not alter the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| t1_esf | input | 1 | T1 framing: 1 = ESF (24 frames), 0 = D4 (12 frames) |
| crc4_en | input | 1 | E1 CRC-4 multiframing enabled |
| rx_frame_pulse | input | 1 | One-cycle strobe at the start of each receive frame |
| rx_mf_sync | input | 1 | With `rx_frame_pulse`: this frame is receive multiframe frame 0 |
| rx_crc4_sync | input | 1 | With `rx_frame_pulse`: receive CRC-4 multiframe starts here |
| rx_ts16 | input | 8 | Receive slot-16 byte of the frame, valid with `rx_frame_pulse` |
| tx_frame_pulse | input | 1 | One-cycle strobe at the start of each transmit frame |
| tx_mf_sync | input | 1 | With `tx_frame_pulse`: this frame is transmit multiframe frame 0 |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = status word, 1 = mask word |
| host_wdata | input | 8 | Host write data (ones clear status bits; mask written as is) |
| host_rdata | output | 8 | Word selected by `host_addr` (combinational) |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
The properties assume the sync inputs and the slot-16 byte matter only in cycles that carry their side's frame pulse, and that each pulse lasts one cycle. The bench drives a sync or CRC-4 strobe only together with a frame pulse, with at least one idle cycle between frames. It also changes the line mode, framing format and CRC-4 setting only between frames, and it resynchronises the multiframe counters after each such change. Since the counters rely on that sync, the expected status values of each table row depend only on the row's own frames.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int unsigned STAT_W = 8;

  // Status bit positions; the host decodes these.
  localparam int unsigned B_RX_ALIGN  = 0;
  localparam int unsigned B_RX_CRC_MF = 1;
  localparam int unsigned B_RX_MF     = 2;
  localparam int unsigned B_TX_ALIGN  = 3;
  localparam int unsigned B_TX_MF     = 4;
  localparam int unsigned B_SIG_ZERO  = 5;
  localparam int unsigned B_SIG_ONES  = 6;

  // Bits that exist in the register (bit 7 is absent).
  localparam logic [STAT_W-1:0] LIVE_BITS = 8'h7F;
  // Bits that only E1 framing can set.
  localparam logic [STAT_W-1:0] E1_ONLY_BITS = 8'h6B;

  typedef enum logic {
    HREG_STATUS = 1'b0,
    HREG_MASK   = 1'b1
  } hreg_e;

endpackage

// File: rtl/fes_frame_counter.sv
module fes_frame_counter #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned E1_LEN  = 16,
  parameter int unsigned D4_LEN  = 12,
  parameter int unsigned ESF_LEN = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  input  logic             mf_sync,
  input  logic             line_e1,
  input  logic             t1_esf,
  output logic [CNT_W-1:0] frame_idx
);

  localparam logic [CNT_W-1:0] E1_LAST  = CNT_W'(E1_LEN - 1);
  localparam logic [CNT_W-1:0] D4_LAST  = CNT_W'(D4_LEN - 1);
  localparam logic [CNT_W-1:0] ESF_LAST = CNT_W'(ESF_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic             cnt_en;

  // Index of the frame whose pulse is present now; sync forces frame 0.
  always_comb begin
    if (line_e1)     last_idx = E1_LAST;
    else if (t1_esf) last_idx = ESF_LAST;
    else             last_idx = D4_LAST;

    frame_idx = mf_sync ? '0 : cnt_q;
    cnt_en    = frame_pulse;
    // A count left beyond the last frame by a mode change wraps as well.
    if (frame_idx >= last_idx) cnt_d = '0;
    else                       cnt_d = frame_idx + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fes_ts16_monitor.sv
module fes_ts16_monitor #(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned SLOT_W     = 8,
  parameter int unsigned WIN_FRAMES = 16,
  parameter int unsigned ZERO_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic              line_e1,
  input  logic [CNT_W-1:0]  frame_idx,
  input  logic [SLOT_W-1:0] ts16,
  output logic              all_zero_evt,
  output logic              all_ones_evt
);

  localparam int unsigned LIM_W = $clog2(ZERO_LIMIT + 1);
  localparam int unsigned SUM_W = $clog2(SLOT_W + ZERO_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_FRAMES - 1);
  localparam logic [SUM_W-1:0] LIM_SUM  = SUM_W'(ZERO_LIMIT);

  logic [LIM_W-1:0] zeros_q;
  logic [LIM_W-1:0] zeros_d;
  logic             one_seen_q;
  logic             one_seen_d;
  logic [SUM_W-1:0] zero_sum;
  logic [SUM_W-1:0] zero_sat;
  logic             win_start;
  logic             win_end;
  logic             acc_en;

  always_comb begin
    win_start  = (frame_idx == '0);
    win_end    = (frame_idx == LAST_IDX);
    acc_en     = frame_pulse;
    zero_sum   = (win_start ? '0 : SUM_W'(zeros_q)) + SUM_W'($countones(~ts16));
    zero_sat   = (zero_sum > LIM_SUM) ? LIM_SUM : zero_sum;
    zeros_d    = LIM_W'(zero_sat);
    one_seen_d = (win_start ? 1'b0 : one_seen_q) | (|ts16);

    all_zero_evt = frame_pulse & line_e1 & win_end & ~one_seen_d;
    all_ones_evt = frame_pulse & line_e1 & win_end & (zero_sat < LIM_SUM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zeros_q    <= '0;
      one_seen_q <= 1'b0;
    end else if (acc_en) begin
      zeros_q    <= zeros_d;
      one_seen_q <= one_seen_d;
    end
  end

endmodule

// File: rtl/fes_status_reg.sv
module fes_status_reg
  import fes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [STAT_W-1:0] host_wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] mask_q
);

  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status_d;
  logic [STAT_W-1:0] mask_d;
  logic              status_en;
  logic              mask_en;

  always_comb begin
    clr_vec   = (host_wr && hreg_e'(host_addr) == HREG_STATUS) ? host_wdata : '0;
    // Set wins over clear on the same bit.
    status_d  = ((status_q & ~clr_vec) | set_vec) & LIVE_BITS;
    status_en = (|set_vec) | (|clr_vec);
    mask_en   = host_wr && hreg_e'(host_addr) == HREG_MASK;
    mask_d    = host_wdata & LIVE_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

endmodule

// File: rtl/fes_event_status.sv
module fes_event_status
  import fes_pkg::*;
#(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned SLOT_W     = 8,
  parameter int unsigned E1_LEN     = 16,
  parameter int unsigned D4_LEN     = 12,
  parameter int unsigned ESF_LEN    = 24,
  parameter int unsigned ALIGN_DIV  = 2,
  parameter int unsigned CRC_LEN    = 16,
  parameter int unsigned ZERO_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_e1,
  input  logic              t1_esf,
  input  logic              crc4_en,
  input  logic              rx_frame_pulse,
  input  logic              rx_mf_sync,
  input  logic              rx_crc4_sync,
  input  logic [SLOT_W-1:0] rx_ts16,
  input  logic              tx_frame_pulse,
  input  logic              tx_mf_sync,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [STAT_W-1:0] host_wdata,
  output logic [STAT_W-1:0] host_rdata,
  output logic              irq
);

  localparam int unsigned SIDES  = 2;  // 0 = receive, 1 = transmit
  localparam logic [CNT_W-1:0] ALIGN_M = CNT_W'(ALIGN_DIV);

  logic [SIDES-1:0] side_pulse;
  logic [SIDES-1:0] side_sync;
  logic [CNT_W-1:0] side_idx [SIDES];
  logic [SIDES-1:0] side_align;
  logic [SIDES-1:0] side_mf;
  logic [CNT_W-1:0] crc_free_idx;
  logic             crc_evt;
  logic             sig_zero_evt;
  logic             sig_ones_evt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;

  assign side_pulse = {tx_frame_pulse, rx_frame_pulse};
  assign side_sync  = {tx_mf_sync, rx_mf_sync};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    fes_frame_counter #(
      .CNT_W(CNT_W), .E1_LEN(E1_LEN), .D4_LEN(D4_LEN), .ESF_LEN(ESF_LEN)
    ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_pulse(side_pulse[s]),
      .mf_sync    (side_sync[s]),
      .line_e1    (line_e1),
      .t1_esf     (t1_esf),
      .frame_idx  (side_idx[s])
    );

    always_comb begin
      side_align[s] = side_pulse[s] & line_e1 & ((side_idx[s] % ALIGN_M) == '0);
      side_mf[s]    = side_pulse[s] & (side_idx[s] == '0);
    end
  end

  // Free-running CRC-4 multiframe timer: never resynchronised.
  fes_frame_counter #(
    .CNT_W(CNT_W), .E1_LEN(CRC_LEN), .D4_LEN(CRC_LEN), .ESF_LEN(CRC_LEN)
  ) u_crc_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_pulse(rx_frame_pulse),
    .mf_sync    (1'b0),
    .line_e1    (1'b1),
    .t1_esf     (1'b0),
    .frame_idx  (crc_free_idx)
  );

  fes_ts16_monitor #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .WIN_FRAMES(E1_LEN), .ZERO_LIMIT(ZERO_LIMIT)
  ) u_ts16 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (rx_frame_pulse),
    .line_e1     (line_e1),
    .frame_idx   (side_idx[0]),
    .ts16        (rx_ts16),
    .all_zero_evt(sig_zero_evt),
    .all_ones_evt(sig_ones_evt)
  );

  always_comb begin
    crc_evt = rx_frame_pulse & line_e1 &
              (crc4_en ? rx_crc4_sync : (crc_free_idx == '0));

    set_vec              = '0;
    set_vec[B_RX_ALIGN]  = side_align[0];
    set_vec[B_RX_CRC_MF] = crc_evt;
    set_vec[B_RX_MF]     = side_mf[0];
    set_vec[B_TX_ALIGN]  = side_align[1];
    set_vec[B_TX_MF]     = side_mf[1];
    set_vec[B_SIG_ZERO]  = sig_zero_evt;
    set_vec[B_SIG_ONES]  = sig_ones_evt;
  end

  fes_status_reg u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .status_q  (status_q),
    .mask_q    (mask_q)
  );

  always_comb begin
    host_rdata = (hreg_e'(host_addr) == HREG_STATUS) ? status_q : mask_q;
    irq        = |(status_q & mask_q);
  end

endmodule

// File: rtl/fes_event_status_chk.sv
module fes_event_status_chk
  import fes_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              line_e1,
  input logic              rx_frame_pulse,
  input logic              tx_frame_pulse,
  input logic              host_wr,
  input logic              host_addr,
  input logic [STAT_W-1:0] host_wdata,
  input logic [STAT_W-1:0] host_rdata,
  input logic [STAT_W-1:0] status_q,
  input logic              irq
);

  logic idle_frames;
  logic stat_write;
  assign idle_frames = !rx_frame_pulse && !tx_frame_pulse;
  assign stat_write  = host_wr && hreg_e'(host_addr) == HREG_STATUS;

  // R1
  unused_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[STAT_W-1] == 1'b0);

  // R8
  t1_no_e1_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_e1 |=> ((status_q & ~$past(status_q) & E1_ONLY_BITS) == '0));

  // R9
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_frames |=> ((status_q & ~$past(status_q)) == '0));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_write |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_write && idle_frames) |=> ((status_q & $past(host_wdata)) == '0));

  // R11
  mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && hreg_e'(host_addr) == HREG_MASK && host_wdata == '0) |=> !irq);

endmodule

bind fes_event_status fes_event_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_e1       (line_e1),
  .rx_frame_pulse(rx_frame_pulse),
  .tx_frame_pulse(tx_frame_pulse),
  .host_wr       (host_wr),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .host_rdata    (host_rdata),
  .status_q      (status_q),
  .irq           (irq)
);

// File: tb/fes_event_status_tb_top.sv
module fes_event_status_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic       e1;
    logic       esf;
    logic       crc;
    logic [7:0] ts;
    logic [7:0] nfr;
    logic [7:0] exp;
  } vec_t;

  // Each row: sync frame, clear, then nfr frames; expected status after.
  localparam vec_t [0:NVEC-1] VECS = '{
    '{1'b1, 1'b0, 1'b1, 8'h55, 8'd1,  8'h00},  // R2 odd index: no align
    '{1'b1, 1'b0, 1'b1, 8'h55, 8'd2,  8'h09},  // R2 align both sides
    '{1'b1, 1'b0, 1'b1, 8'h55, 8'd8,  8'h09},  // R2
    '{1'b1, 1'b0, 1'b1, 8'h55, 8'd15, 8'h09},  // R3 R6 R7 none yet
    '{1'b1, 1'b0, 1'b1, 8'h55, 8'd16, 8'h1F},  // R3 R4 E1 multiframe
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'd15, 8'h29},  // R6 all zeros
    '{1'b1, 1'b0, 1'b1, 8'hFF, 8'd15, 8'h49},  // R7 all ones
    '{1'b0, 1'b0, 1'b0, 8'hFF, 8'd11, 8'h00},  // R3 R8 D4 before wrap
    '{1'b0, 1'b0, 1'b0, 8'hFF, 8'd12, 8'h14},  // R3 D4 wrap
    '{1'b0, 1'b1, 1'b0, 8'h55, 8'd12, 8'h00},  // R3 ESF mid
    '{1'b0, 1'b1, 1'b0, 8'h55, 8'd23, 8'h00},  // R3 ESF before wrap
    '{1'b0, 1'b1, 1'b0, 8'h55, 8'd24, 8'h14},  // R3 ESF wrap
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'd15, 8'h14}   // R8 no slot-16 alarm
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_e1 = 1'b1;
  logic       t1_esf = 1'b0;
  logic       crc4_en = 1'b0;
  logic       rx_frame_pulse = 1'b0;
  logic       rx_mf_sync = 1'b0;
  logic       rx_crc4_sync = 1'b0;
  logic [7:0] rx_ts16 = 8'h55;
  logic       tx_frame_pulse = 1'b0;
  logic       tx_mf_sync = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int b_idx = 0;
  int b_len = 16;

  always #(CLK_PERIOD/2) clk = ~clk;

  fes_event_status dut_i (
    .clk(clk), .rst_n(rst_n), .line_e1(line_e1), .t1_esf(t1_esf),
    .crc4_en(crc4_en), .rx_frame_pulse(rx_frame_pulse), .rx_mf_sync(rx_mf_sync),
    .rx_crc4_sync(rx_crc4_sync), .rx_ts16(rx_ts16), .tx_frame_pulse(tx_frame_pulse),
    .tx_mf_sync(tx_mf_sync), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic frame(input logic rx, input logic tx, input logic sync, input logic crcs);
    @(negedge clk);
    rx_frame_pulse = rx; tx_frame_pulse = tx;
    rx_mf_sync = rx & sync; tx_mf_sync = tx & sync; rx_crc4_sync = rx & crcs;
    @(negedge clk);
    rx_frame_pulse = 1'b0; tx_frame_pulse = 1'b0;
    rx_mf_sync = 1'b0; tx_mf_sync = 1'b0; rx_crc4_sync = 1'b0;
  endtask

  // Framer stub: both sides in step, sync on frame 0.
  task automatic run_frame();
    logic s;
    s = (b_idx == 0);
    frame(1'b1, 1'b1, s, s & line_e1 & crc4_en);
    b_idx = (b_idx + 1) % b_len;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); check("R1 status after reset", v, 8'h00);
    rd(1'b1, v); check("R1 mask after reset", v, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);

    // R5 free-running CRC-4 event with CRC-4 off, sync ignored
    line_e1 = 1'b1; crc4_en = 1'b0;
    frame(1'b1, 1'b0, 1'b0, 1'b0);
    rd(1'b0, v); check("R5 first frame after reset", v & 8'h02, 8'h02);
    wr(1'b0, 8'hFF);
    for (int i = 2; i <= 16; i++) frame(1'b1, 1'b0, i == 5, i == 5);
    rd(1'b0, v); check("R5 no event frames 2..16", v & 8'h02, 8'h00);
    frame(1'b1, 1'b0, 1'b0, 1'b0);
    rd(1'b0, v); check("R5 event on frame 17", v & 8'h02, 8'h02);

    // R10 set and clear in the same cycle
    @(negedge clk);
    rx_frame_pulse = 1'b1; rx_mf_sync = 1'b1;
    host_wr = 1'b1; host_addr = 1'b0; host_wdata = 8'hFF;
    @(negedge clk);
    rx_frame_pulse = 1'b0; rx_mf_sync = 1'b0; host_wr = 1'b0;
    rd(1'b0, v); check("R10 set wins over clear", v, 8'h05);

    // R9 partial write-one-to-clear and stickiness
    wr(1'b0, 8'h01);
    rd(1'b0, v); check("R9 clear bit 0 only", v, 8'h04);
    wr(1'b0, 8'h00);
    repeat (5) @(negedge clk);
    rd(1'b0, v); check("R9 zero write and idle keep bits", v, 8'h04);
    wr(1'b0, 8'h04);
    rd(1'b0, v); check("R9 clear bit 2", v, 8'h00);

    // R1 bit 7 of mask
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R1 mask bit 7 reads 0", v, 8'h7F);

    // R11 interrupt masking
    check("R11 irq low with empty status", {7'd0, irq}, 8'h00);
    wr(1'b1, 8'h04);
    frame(1'b0, 1'b1, 1'b1, 1'b0);
    check("R11 masked tx events keep irq low", {7'd0, irq}, 8'h00);
    frame(1'b1, 1'b0, 1'b1, 1'b0);
    check("R11 unmasked rx multiframe raises irq", {7'd0, irq}, 8'h01);
    wr(1'b1, 8'h00);
    check("R11 zero mask drops irq", {7'd0, irq}, 8'h00);
    rd(1'b0, v); check("R11 mask write leaves status", v & 8'hFD, 8'h1D);

    // Table of rows: R2 R3 R4 R6 R7 R8
    for (int n = 0; n < NVEC; n++) begin
      line_e1 = VECS[n].e1; t1_esf = VECS[n].esf; crc4_en = VECS[n].crc;
      rx_ts16 = VECS[n].ts;
      b_len = VECS[n].e1 ? 16 : (VECS[n].esf ? 24 : 12);
      b_idx = 0;
      run_frame();
      wr(1'b0, 8'hFF);
      for (int f = 0; f < int'(VECS[n].nfr); f++) run_frame();
      rd(1'b0, v);
      check($sformatf("R2,R3,R4,R6,R7,R8 row %0d", n), v, VECS[n].exp);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule